// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the operand address for a CPU with 32-bit addresses. Each request gives an addressing-mode code, a snapshot of the pointer registers (BC, DE, HL, IX, IY, SP, PC), the address or displacement bytes taken from the instruction, and the state of the width-extension prefix. The unit returns a 32-bit effective address, a flag that marks an I/O-space access, an address-valid flag and an illegal-combination flag. All four results are registered one cycle after a start strobe.

The width-extension prefix sets the field width separately for each request. With no prefix, direct addresses are 16 bits and displacements are 8 bits. A byte-extend prefix raises these to 24 and 16 bits. A word-extend prefix raises them to 32 and 24 bits. Displacements are sign-extended before the add. Direct addresses are zero-extended. Every sum wraps modulo 2^32.

Top module: `eag_top`

## Requirements
- R1: The unit samples its inputs only on a cycle where `start` is 1. On the next cycle `done` is 1 and the results are updated. On every other cycle `done` is 0 and all four results hold their previous values, whatever the inputs do.
- R2: Register mode (`mode`=0) and immediate mode (`mode`=1) give `ea_valid`=0, `illegal`=0, `io_space`=0 and `ea`=0.
- R3: Indirect mode (`mode`=2) uses pointer code `ptr_sel`=0 for BC, 1 for DE or 2 for HL, and `ea` is that register. `io_space` follows `io_req`. If `io_req`=1 with any pointer other than BC, the request is illegal.
- R4: In indirect mode, IX (`ptr_sel`=3) and IY (`ptr_sel`=4) are legal only when `iclass`=1 (jump). With `iclass` 0 (data), 2 (call) or 3 (data) they are illegal. Pointer codes 5 to 7 are always illegal.
- R5: Direct mode (`mode`=3) gives the low 16, 24 or 32 bits of `field`, zero-extended, for `ext` 0, 1 or 2 respectively. `io_space` follows `io_req`.
- R6: Indexed mode (`mode`=4) requires `ptr_sel` 3 (IX) or 4 (IY); any other code is illegal. `ea` is the base plus the low 8, 16 or 24 bits of `field`, sign-extended, for `ext` 0, 1 or 2.
- R7: Stack-relative mode (`mode`=5) gives SP plus the sign-extended displacement. The displacement width follows the same rule as in R6.
- R8: PC-relative mode (`mode`=6) gives PC plus the sign-extended displacement, with the widths of R6. It is legal only for `iclass` 1 (jump) or 2 (call).
- R9: `ext`=3 and `mode`=7 are illegal. Any illegal request gives `illegal`=1, `ea_valid`=0, `io_space`=0 and `ea`=0.
- R10: Displacement sums wrap modulo 2^32.
- R11: `io_req` is ignored outside indirect and direct modes, and `io_space` stays 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; inputs are sampled when this is high |
| mode | input | 3 | Addressing-mode code |
| ext | input | 2 | Width-extension prefix: 0 none, 1 byte, 2 word, 3 reserved |
| ptr_sel | input | 3 | Pointer code: 0 BC, 1 DE, 2 HL, 3 IX, 4 IY |
| iclass | input | 2 | Instruction class: 0 data, 1 jump, 2 call, 3 data |
| io_req | input | 1 | The instruction targets I/O space |
| reg_bc | input | 32 | BC snapshot |
| reg_de | input | 32 | DE snapshot |
| reg_hl | input | 32 | HL snapshot |
| reg_ix | input | 32 | IX snapshot |
| reg_iy | input | 32 | IY snapshot |
| reg_sp | input | 32 | SP snapshot |
| reg_pc | input | 32 | PC snapshot |
| field | input | 32 | Instruction address/displacement bytes, least significant first |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | An effective address was formed |
| io_space | output | 1 | The address is in I/O space |
| illegal | output | 1 | Illegal mode/pointer/class/prefix combination |
| done | output | 1 | Result strobe, one cycle after start |

## Verification
Every request is fully settled one cycle after its start strobe, so any internal fault shows at the ports on the first `done` after the fault. A wrong width choice for a given prefix damages only the upper address bits. A sign- or zero-extension error shows only for fields whose top bit is set. Legality faults show as a disagreement between `illegal` and `ea_valid`. The sweep therefore drives every combination of mode, prefix, pointer, class and space under field patterns whose top bits are set and clear at each width, and it includes one pattern whose sums cross 2^32.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        AM_REG = 3'd0,
        AM_IMM = 3'd1,
        AM_IND = 3'd2,
        AM_DIR = 3'd3,
        AM_IDX = 3'd4,
        AM_SPR = 3'd5,
        AM_PCR = 3'd6,
        AM_BAD = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        WX_NONE = 2'd0,
        WX_BYTE = 2'd1,
        WX_WORD = 2'd2,
        WX_RSVD = 2'd3
    } wext_e;

    typedef enum logic [2:0] {
        PT_BC = 3'd0,
        PT_DE = 3'd1,
        PT_HL = 3'd2,
        PT_IX = 3'd3,
        PT_IY = 3'd4
    } ptr_e;

    typedef enum logic [1:0] {
        IC_DATA = 2'd0,
        IC_JUMP = 2'd1,
        IC_CALL = 2'd2,
        IC_DAT2 = 2'd3
    } iclass_e;

    typedef struct packed {
        logic [ADDR_W-1:0] bc;
        logic [ADDR_W-1:0] de;
        logic [ADDR_W-1:0] hl;
        logic [ADDR_W-1:0] ix;
        logic [ADDR_W-1:0] iy;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] pc;
    } regsnap_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              add_disp;
        logic              take_dir;
        logic              forms_addr;
        logic              legal;
        logic              io;
    } route_t;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic              valid;
        logic              io;
        logic              bad;
    } result_t;

    // Field widths per prefix, direct and displacement
    function automatic int dir_bits(wext_e w);
        case (w)
            WX_BYTE: return 24;
            WX_WORD: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic int disp_bits(wext_e w);
        case (w)
            WX_BYTE: return 16;
            WX_WORD: return 24;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/eag_field_fmt.sv
module eag_field_fmt
    import eag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  wext_e         wext,
    input  logic [AW-1:0] raw,
    output logic [AW-1:0] disp_sx,
    output logic [AW-1:0] dir_zx,
    output logic          wext_ok
);
    int dw;
    int aw;

    always_comb begin
        dw      = disp_bits(wext);
        aw      = dir_bits(wext);
        wext_ok = (wext != WX_RSVD);
        disp_sx = '0;
        dir_zx  = '0;
        for (int i = 0; i < AW; i++) begin
            disp_sx[i] = (i < dw) ? raw[i] : raw[dw-1];
            dir_zx[i]  = (i < aw) ? raw[i] : 1'b0;
        end
    end
endmodule

// File: rtl/eag_base_sel.sv
module eag_base_sel
    import eag_pkg::*;
(
    input  amode_e   am,
    input  logic [2:0] ptr,
    input  iclass_e  cls,
    input  logic     io_req,
    input  regsnap_t rs,
    output route_t   rt
);
    always_comb begin
        rt = '0;
        rt.legal = 1'b1;
        case (am)
            AM_REG, AM_IMM: begin
                rt.forms_addr = 1'b0;
            end
            AM_IND: begin
                rt.forms_addr = 1'b1;
                rt.io         = io_req;
                case (ptr)
                    PT_BC: rt.base = rs.bc;
                    PT_DE: rt.base = rs.de;
                    PT_HL: rt.base = rs.hl;
                    PT_IX: begin
                        rt.base  = rs.ix;
                        rt.legal = (cls == IC_JUMP);
                    end
                    PT_IY: begin
                        rt.base  = rs.iy;
                        rt.legal = (cls == IC_JUMP);
                    end
                    default: rt.legal = 1'b0;
                endcase
                if (io_req && ptr != PT_BC) rt.legal = 1'b0;
            end
            AM_DIR: begin
                rt.forms_addr = 1'b1;
                rt.take_dir   = 1'b1;
                rt.io         = io_req;
            end
            AM_IDX: begin
                rt.forms_addr = 1'b1;
                rt.add_disp   = 1'b1;
                case (ptr)
                    PT_IX:   rt.base = rs.ix;
                    PT_IY:   rt.base = rs.iy;
                    default: rt.legal = 1'b0;
                endcase
            end
            AM_SPR: begin
                rt.forms_addr = 1'b1;
                rt.add_disp   = 1'b1;
                rt.base       = rs.sp;
            end
            AM_PCR: begin
                rt.forms_addr = 1'b1;
                rt.add_disp   = 1'b1;
                rt.base       = rs.pc;
                rt.legal      = (cls == IC_JUMP) || (cls == IC_CALL);
            end
            default: rt.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  mode,
    input  logic [1:0]  ext,
    input  logic [2:0]  ptr_sel,
    input  logic [1:0]  iclass,
    input  logic        io_req,
    input  logic [31:0] reg_bc,
    input  logic [31:0] reg_de,
    input  logic [31:0] reg_hl,
    input  logic [31:0] reg_ix,
    input  logic [31:0] reg_iy,
    input  logic [31:0] reg_sp,
    input  logic [31:0] reg_pc,
    input  logic [31:0] field,
    output logic [31:0] ea,
    output logic        ea_valid,
    output logic        io_space,
    output logic        illegal,
    output logic        done
);
    regsnap_t            snap;
    route_t              rt;
    logic [ADDR_W-1:0]   disp_sx;
    logic [ADDR_W-1:0]   dir_zx;
    logic                wext_ok;
    result_t             nxt;
    result_t             cur;
    logic                done_q;

    assign snap = '{bc: reg_bc, de: reg_de, hl: reg_hl, ix: reg_ix,
                    iy: reg_iy, sp: reg_sp, pc: reg_pc};

    eag_field_fmt #(.AW(ADDR_W)) u_fmt (
        .wext    (wext_e'(ext)),
        .raw     (field),
        .disp_sx (disp_sx),
        .dir_zx  (dir_zx),
        .wext_ok (wext_ok)
    );

    eag_base_sel u_sel (
        .am     (amode_e'(mode)),
        .ptr    (ptr_sel),
        .cls    (iclass_e'(iclass)),
        .io_req (io_req),
        .rs     (snap),
        .rt     (rt)
    );

    always_comb begin
        nxt       = '0;
        nxt.bad   = !(rt.legal && wext_ok);
        nxt.valid = rt.forms_addr && !nxt.bad;
        nxt.io    = nxt.valid && rt.io;
        if (nxt.valid) begin
            if (rt.take_dir) nxt.ea = dir_zx;
            else             nxt.ea = rt.base + (rt.add_disp ? disp_sx : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start) cur <= nxt;
        end
    end

    assign ea       = cur.ea;
    assign ea_valid = cur.valid;
    assign io_space = cur.io;
    assign illegal  = cur.bad;
    assign done     = done_q;
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [2:0]  mode,
    input logic [1:0]  ext,
    input logic [2:0]  ptr_sel,
    input logic [1:0]  iclass,
    input logic        io_req,
    input logic [31:0] ea,
    input logic        ea_valid,
    input logic        io_space,
    input logic        illegal,
    input logic        done
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R1
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && $stable(ea) && $stable(ea_valid)
                    && $stable(io_space) && $stable(illegal))); // R1
    AST_NO_ADDR_REG_IMM: assert property (@(posedge clk) disable iff (rst)
        (start && (mode == 3'd0 || mode == 3'd1) && ext != 2'd3)
        |=> (!ea_valid && !illegal)); // R2
    AST_IO_NEEDS_BC: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 3'd2 && io_req && ptr_sel != 3'd0) |=> illegal); // R3
    AST_PCR_CLASS: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 3'd6 && iclass != 2'd1 && iclass != 2'd2)
        |=> illegal); // R8
    AST_ILLEGAL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!ea_valid && !io_space && ea == 32'd0)); // R9
    AST_IO_MODES: assert property (@(posedge clk) disable iff (rst)
        (start && mode >= 3'd4) |=> !io_space); // R11
endmodule

bind eag_top eag_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ext(ext),
    .ptr_sel(ptr_sel), .iclass(iclass), .io_req(io_req), .ea(ea),
    .ea_valid(ea_valid), .io_space(io_space), .illegal(illegal), .done(done)
);

// File: tb/tb_eag_top.sv
module tb_eag_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic [1:0]  ext;
    logic [2:0]  ptr_sel;
    logic [1:0]  iclass;
    logic        io_req;
    logic [31:0] reg_bc, reg_de, reg_hl, reg_ix, reg_iy, reg_sp, reg_pc, field;
    logic [31:0] ea;
    logic        ea_valid, io_space, illegal, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_top dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .ext(ext),
        .ptr_sel(ptr_sel), .iclass(iclass), .io_req(io_req),
        .reg_bc(reg_bc), .reg_de(reg_de), .reg_hl(reg_hl), .reg_ix(reg_ix),
        .reg_iy(reg_iy), .reg_sp(reg_sp), .reg_pc(reg_pc), .field(field),
        .ea(ea), .ea_valid(ea_valid), .io_space(io_space),
        .illegal(illegal), .done(done)
    );

    function automatic logic [31:0] sx(logic [31:0] f, int w);
        logic [31:0] r;
        r = f;
        for (int i = w; i < 32; i++) r[i] = f[w-1];
        return r;
    endfunction

    function automatic logic [31:0] zx(logic [31:0] f, int w);
        logic [31:0] r;
        r = f;
        for (int i = w; i < 32; i++) r[i] = 1'b0;
        return r;
    endfunction

    // Expected result: {ea, valid, io, illegal}
    function automatic logic [34:0] model();
        logic [31:0] e;
        logic v, io, bad, forms;
        int dw, aw;
        e = 0; io = 0; bad = 0; forms = 1;
        dw = (ext == 1) ? 16 : (ext == 2) ? 24 : 8;
        aw = (ext == 1) ? 24 : (ext == 2) ? 32 : 16;
        case (mode)
            0, 1: forms = 0;
            2: begin
                io = io_req;
                case (ptr_sel)
                    0: e = reg_bc;
                    1: e = reg_de;
                    2: e = reg_hl;
                    3: begin e = reg_ix; bad = (iclass != 1); end
                    4: begin e = reg_iy; bad = (iclass != 1); end
                    default: bad = 1;
                endcase
                if (io_req && ptr_sel != 0) bad = 1;
            end
            3: begin e = zx(field, aw); io = io_req; end
            4: begin
                if (ptr_sel == 3)      e = reg_ix + sx(field, dw);
                else if (ptr_sel == 4) e = reg_iy + sx(field, dw);
                else bad = 1;
            end
            5: e = reg_sp + sx(field, dw);
            6: begin
                e = reg_pc + sx(field, dw);
                bad = !(iclass == 1 || iclass == 2);
            end
            default: bad = 1;
        endcase
        if (ext == 3) bad = 1;
        v = forms && !bad;
        if (!v) begin e = 0; io = 0; end
        return {e, v, io, bad};
    endfunction

    function automatic string tag();
        if (ext == 3 || mode == 7) return "R9";
        case (mode)
            0, 1: return "R2";
            2: return (ptr_sel >= 3) ? "R4" : "R3";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [34:0] act, logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got ea=%h v=%b io=%b ill=%b, expected ea=%h v=%b io=%b ill=%b",
                     req, act[34:3], act[2], act[1], act[0],
                     exp[34:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b, expected %b", req, act, exp);
        end
    endtask

    // Issue one request and check the registered result
    task automatic run_op(string req);
        logic [34:0] exp;
        @(negedge clk);
        start = 1'b1;
        exp = model();
        @(negedge clk);
        start = 1'b0;
        check_bit({req, " done"}, done, 1'b1);
        check(req, {ea, ea_valid, io_space, illegal}, exp);
    endtask

    task automatic set_regs(int p);
        case (p)
            0: begin
                reg_bc = 32'h1000_0010; reg_de = 32'h2000_0020; reg_hl = 32'h3000_0030;
                reg_ix = 32'h4000_1000; reg_iy = 32'h5000_2000;
                reg_sp = 32'h6000_8000; reg_pc = 32'h7000_0100;
                field  = 32'h5A7F_FF80;
            end
            1: begin
                reg_bc = 32'hB1B2_B3B4; reg_de = 32'hD1D2_D3D4; reg_hl = 32'hE1E2_E3E4;
                reg_ix = 32'h0000_0040; reg_iy = 32'h0001_0000;
                reg_sp = 32'h0000_0000; reg_pc = 32'h0000_0010;
                field  = 32'hA580_007F;
            end
            default: begin
                reg_bc = 32'h0; reg_de = 32'hFFFF_FFFF; reg_hl = 32'h8000_0000;
                reg_ix = 32'hFFFF_FFF0; reg_iy = 32'hFFFF_0000;
                reg_sp = 32'hFFFF_FF00; reg_pc = 32'hFFFF_FFF0;
                field  = 32'h7F7F_7F50;
            end
        endcase
    endtask

    initial begin
        logic [34:0] held;
        rst = 1'b1; start = 1'b0; mode = 0; ext = 0; ptr_sel = 0;
        iclass = 0; io_req = 0;
        set_regs(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", {ea, ea_valid, io_space, illegal}, 35'd0);
        check_bit("R1 reset done", done, 1'b0);

        for (int p = 0; p < 3; p++) begin
            set_regs(p);
            for (int m = 0; m < 8; m++)
                for (int x = 0; x < 4; x++)
                    for (int q = 0; q < 8; q++)
                        for (int c = 0; c < 4; c++)
                            for (int o = 0; o < 2; o++) begin
                                mode = m[2:0]; ext = x[1:0]; ptr_sel = q[2:0];
                                iclass = c[1:0]; io_req = o[0];
                                run_op(tag());
                            end
        end

        // R10: explicit wrap past 2^32 (PC relative, jump)
        set_regs(2);
        mode = 3'd6; ext = 2'd0; iclass = 2'd1; io_req = 0; ptr_sel = 0;
        run_op("R10");
        check("R10 wrap", {ea, ea_valid, io_space, illegal}, {32'h0000_0040, 3'b100});

        // R11: I/O request ignored in stack-relative mode
        mode = 3'd5; io_req = 1'b1; ext = 2'd1;
        run_op("R11");
        check_bit("R11 io_space", io_space, 1'b0);

        // R1: inputs ignored while start is low
        mode = 3'd3; ext = 2'd2; io_req = 1'b0;
        run_op("R1");
        held = {ea, ea_valid, io_space, illegal};
        mode = 3'd7; field = 32'h1234_5678; ext = 2'd3;
        repeat (4) @(negedge clk);
        check("R1 hold", {ea, ea_valid, io_space, illegal}, held);
        check_bit("R1 no done", done, 1'b0);

        finished = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule